// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital control core of an 8-bit successive-approximation converter. An external DAC receives the controller's trial code, and an external comparator returns one decision bit. The controller runs a binary search on falling edges of the conversion clock. It works from the most significant bit down to the least significant bit. When the search ends, the controller holds the result until the next start request.

The start input is active low and acts as an asynchronous preset. Pulling it low loads the mid-scale trial code and marks the converter busy, with no clock edge needed. The search begins on the first falling clock edge after the start input returns high. The busy flag returns high on the ninth such edge. After that, the controller ignores the clock until the next start request.

The result is read through a data port that has a separate output enable. The port drives the result only while the read enable is high and floats otherwise. Reading leaves the result unchanged. The busy flag may be wired directly to the read enable, so that the result appears on the shared bus as soon as the conversion is complete.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After rst_ni is asserted and before any start request, busy_no is 1 and trial_o and the held result are 8'h00.
- R2: A falling edge on start_ni sets trial_o to 8'h80 (bit 7, the MSB, set and all other bits clear) and drives busy_no to 0 at once, with no clock edge needed.
- R3: While start_ni stays low, trial_o stays at 8'h80 and busy_no stays at 0 on every clock edge, whatever cmp_i reports.
- R4: Each falling clock edge after start_ni is released decides one bit, starting with the MSB. The bit under trial stays 1 when cmp_i is 1 and is cleared to 0 when cmp_i is 0. On the same edge, the next lower bit is set to 1.
- R5: busy_no stays 0 through the eighth falling edge after start_ni is released and rises to 1 on the ninth. From that edge on, the result is valid.
- R6: The result is offset binary. With an ideal comparator (cmp_i = 1 when the input code is at or above the trial code), the result equals the input code: 8'h00 at the bottom, 8'h80 at mid-scale and 8'hFF at full scale minus one LSB.
- R7: Once the conversion is complete, clock edges and cmp_i have no effect. busy_no stays 1 and the result stays frozen until start_ni falls again.
- R8: data_oe_o follows rd_en_i. data_o carries the held result while rd_en_i is 1 and is high impedance while rd_en_i is 0. Toggling rd_en_i does not change the result.
- R9: When busy_no is wired to rd_en_i, the data port is disabled for the whole conversion and enabled from the completing edge onward, carrying the correct result.
- R10: A start falling edge that lands during a conversion, including one at the same instant as a falling clock edge, takes priority over the bit decision. trial_o returns to 8'h80 with busy_no at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock; decisions are made on falling edges |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| start_ni | input | 1 | Active-low start; preset and inhibit while low |
| cmp_i | input | 1 | Comparator decision; 1 keeps the bit under trial |
| trial_o | output | 8 | Trial code to the DAC; holds the result after completion |
| busy_no | output | 1 | Low while a conversion is pending or running |
| rd_en_i | input | 1 | Read enable for the data port |
| data_o | output | 8 | Held result; high impedance while the read enable is low |
| data_oe_o | output | 1 | Output enable of the data port |

## Verification
The asynchronous start preset and the clocked bit decision can happen at the same instant. To provoke this, the bench drops start_ni exactly on a falling clock edge partway through a conversion. The outcome is judged by checking that the trial code is 8'h80 and busy_no is low immediately afterwards, with no trace of the decision that edge would otherwise have made. The restarted conversion must then deliver its own input code through the scoreboard.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DefWidth = 8;

  // one search step: resolve the bit under trial, arm the next lower one
  function automatic logic [DefWidth-1:0] step_code(
    input logic [DefWidth-1:0] code,
    input logic [DefWidth-1:0] ptr,
    input logic                keep
  );
    return (code & ~ptr) | (keep ? ptr : '0) | (ptr >> 1);
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned Width = sar_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  output logic [Width-1:0] ptr_o,
  output logic             busy_no
);
  localparam logic [Width-1:0] MsbOne = {1'b1, {(Width-1){1'b0}}};

  logic [Width-1:0] ptr_q;
  logic             busy_nq;

  always_ff @(negedge clk_i or negedge rst_ni or negedge start_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      busy_nq <= 1'b1;
    end else if (!start_ni) begin
      ptr_q   <= MsbOne;
      busy_nq <= 1'b0;
    end else if (!busy_nq) begin
      // pointer empty: all bits resolved, this edge completes
      if (ptr_q == '0) busy_nq <= 1'b1;
      ptr_q <= ptr_q >> 1;
    end
  end

  assign ptr_o   = ptr_q;
  assign busy_no = busy_nq;
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int unsigned Width = sar_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             cmp_i,
  input  logic [Width-1:0] ptr_i,
  output logic [Width-1:0] code_o
);
  localparam logic [Width-1:0] MidCode = {1'b1, {(Width-1){1'b0}}};

  logic [Width-1:0] code_q;

  always_ff @(negedge clk_i or negedge rst_ni or negedge start_ni) begin
    if (!rst_ni)        code_q <= '0;
    else if (!start_ni) code_q <= MidCode;
    else                code_q <= sar_pkg::step_code(code_q, ptr_i, cmp_i); // ptr 0 => hold
  end

  assign code_o = code_q;
endmodule

// File: rtl/sar_bus_drv.sv
module sar_bus_drv #(
  parameter int unsigned Width = sar_pkg::DefWidth
) (
  input  logic             rd_en_i,
  input  logic [Width-1:0] code_i,
  output logic [Width-1:0] data_o,
  output logic             oe_o
);
  assign oe_o   = rd_en_i;
  assign data_o = rd_en_i ? code_i : {Width{1'bz}};
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned Width = sar_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             cmp_i,
  output logic [Width-1:0] trial_o,
  output logic             busy_no,
  input  logic             rd_en_i,
  output logic [Width-1:0] data_o,
  output logic             data_oe_o
);
  logic [Width-1:0] ptr;
  logic [Width-1:0] code;

  sar_seq #(.Width(Width)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .ptr_o   (ptr),
    .busy_no (busy_no)
  );

  sar_code_reg #(.Width(Width)) u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .cmp_i   (cmp_i),
    .ptr_i   (ptr),
    .code_o  (code)
  );

  sar_bus_drv #(.Width(Width)) u_bus (
    .rd_en_i(rd_en_i),
    .code_i (code),
    .data_o (data_o),
    .oe_o   (data_oe_o)
  );

  assign trial_o = code;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned Width = sar_pkg::DefWidth
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_ni,
  input logic [Width-1:0] trial_o,
  input logic             busy_no
);
  localparam logic [Width-1:0] MidCode = {1'b1, {(Width-1){1'b0}}};

  // R2 / R3: start held low keeps the preset state
  a_r2_preset_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !start_ni |-> (trial_o == MidCode && !busy_no));

  // R4: a decision edge changes at most the trial bit and the next one
  a_r4_two_bits_max: assert property (@(negedge clk_i) disable iff (!rst_ni || !start_ni)
    !busy_no |=> ($countones(trial_o ^ $past(trial_o)) <= 2));

  // R5: the completing edge leaves the result untouched
  a_r5_done_keeps_code: assert property (@(negedge clk_i) disable iff (!rst_ni || !start_ni)
    $rose(busy_no) |-> $stable(trial_o));

  // R7: idle controller is frozen
  a_r7_idle_frozen: assert property (@(negedge clk_i) disable iff (!rst_ni || !start_ni)
    (busy_no && $past(busy_no)) |-> $stable(trial_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.Width(Width)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_ni(start_ni),
  .trial_o (trial_o),
  .busy_no (busy_no)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/100ps
module sar_conv_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       rd_drv = 1'b0;
  logic       tie = 1'b0;
  logic [7:0] vin = 8'h00;
  logic [7:0] trial;
  logic [7:0] data;
  logic       busy_n, oe, cmp, rd_en;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  // ideal comparator: input code at or above trial level keeps the bit
  assign cmp   = (vin >= trial);
  assign rd_en = tie ? busy_n : rd_drv;

  sar_conv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .cmp_i(cmp),
    .trial_o(trial), .busy_no(busy_n), .rd_en_i(rd_en),
    .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: one full conversion, expected result queued for the monitor
  task automatic convert(input logic [7:0] s);
    vin = s;
    exp_q.push_back(s);
    @(posedge clk); start_n = 1'b0;
    @(posedge clk); start_n = 1'b1;
    repeat (9) @(posedge clk);
    #1;
  endtask

  // monitor: completion with busy tied to the read enable
  always @(posedge busy_n) begin
    if (mon_en) begin
      #1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", data, 8'hxx);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(oe == 1'b1, "R9 oe at completion", {7'd0, oe}, 8'h01);
        chk(data == e, "R6 result", data, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rd_drv = 1'b1;
    #12;
    // R1 power-up state
    chk(busy_n == 1'b1, "R1 busy", {7'd0, busy_n}, 8'h01);
    chk(trial == 8'h00, "R1 trial", trial, 8'h00);
    chk(data == 8'h00, "R1 result", data, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 asynchronous preset mid clock phase
    start_n = 1'b0;
    #0.5;
    chk(trial == 8'h80 && busy_n == 1'b0, "R2 preset", trial, 8'h80);

    // R3 held while start low, comparator says clear
    vin = 8'h00;
    repeat (5) @(posedge clk);
    #1;
    chk(trial == 8'h80, "R3 hold trial", trial, 8'h80);
    chk(busy_n == 1'b0, "R3 hold busy", {7'd0, busy_n}, 8'h00);

    // R4 / R5 stepwise on 0110_0110
    vin = 8'h66;
    @(posedge clk); start_n = 1'b1;
    @(posedge clk); #1;
    chk(trial == 8'h40, "R4 MSB decision", trial, 8'h40);
    @(posedge clk); #1;
    chk(trial == 8'h60, "R4 bit6 kept", trial, 8'h60);
    @(posedge clk); #1;
    chk(trial == 8'h70, "R4 bit5 kept", trial, 8'h70);
    repeat (5) @(posedge clk);
    #1;
    chk(trial == 8'h66, "R4 all bits", trial, 8'h66);
    chk(busy_n == 1'b0, "R5 busy low after eighth edge", {7'd0, busy_n}, 8'h00);
    @(posedge clk); #1;
    chk(busy_n == 1'b1, "R5 busy high after ninth edge", {7'd0, busy_n}, 8'h01);

    // R7 idle ignores clock and comparator
    vin = 8'hFF;
    repeat (6) @(posedge clk);
    #1;
    chk(trial == 8'h66 && busy_n, "R7 frozen", trial, 8'h66);

    // R8 read enable
    rd_drv = 1'b0; #1;
    chk(oe == 1'b0, "R8 oe off", {7'd0, oe}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      rd_drv = 1'b1; #1;
      chk(oe == 1'b1 && data == 8'h66, "R8 read", data, 8'h66);
      rd_drv = 1'b0; #1;
    end
    chk(trial == 8'h66, "R8 read non-destructive", trial, 8'h66);

    // R9 busy wired to read enable
    tie = 1'b1;
    mon_en = 1'b1;
    vin = 8'h3C;
    exp_q.push_back(8'h3C);
    @(posedge clk); start_n = 1'b0;
    @(posedge clk); start_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(oe == 1'b0, "R9 oe off during conversion", {7'd0, oe}, 8'h00);
    repeat (5) @(posedge clk);
    #1;

    // R6 corner and random codes through the scoreboard
    convert(8'h00);
    convert(8'hFF);
    convert(8'h80);
    convert(8'h7F);
    for (int i = 0; i < 10; i++) convert(8'($urandom));

    // R10 restart coincident with a falling clock edge
    vin = 8'hA5;
    @(posedge clk); start_n = 1'b0;
    @(posedge clk); start_n = 1'b1;
    repeat (3) @(negedge clk);
    start_n = 1'b0;
    #1;
    chk(trial == 8'h80 && busy_n == 1'b0, "R10 preset wins", trial, 8'h80);
    vin = 8'h19;
    exp_q.push_back(8'h19);
    @(posedge clk); start_n = 1'b1;
    repeat (9) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R10 restarted result delivered", 8'(exp_q.size()), 8'h00);
    chk(checks >= 12, "R6 check count", 8'(checks), 8'd12);
    finish_run();
  end
endmodule